// File: doc/BRIEF.md
# Dual-Mode 64-bit Lane Descrambler

This block recovers plain 64-bit lane words from a scrambled serial lane that has already been cut into words and headers. A single datapath works in either of two modes, chosen at run time on a per-word basis. In self-synchronous mode, the sequence that unscrambles the data is built from the received scrambled bits themselves. This mode suits a 10GBASE-R style link, where words arrive straight from the block aligner. In frame-synchronous mode, a free-running 58-bit additive generator produces the keystream. That generator is reseeded from an in-band seed word whenever block lock holds. This mode suits an Interlaken style link, where words arrive after disparity correction.

Both modes use the polynomial 1 + x^39 + x^58. Within a word, bits are taken least significant bit first. The 2-bit header is never scrambled. It travels beside the data with the same one-cycle latency. The live 58-bit state register is always driven out, so that a downstream frame synchronizer can compare it against the seed words it sees.

Top module: `lane_descrambler`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, desc_valid is 0 and gen_state equals the RESET_SEED parameter (all ones by default).
- R2: With mode_frame=0, each output bit i is the received bit XOR the received bits 39 and 58 positions earlier in the stream. The stream runs through bit 0 up to bit 63 of each word, and the history carries across words.
- R3: With mode_frame=0, a valid word leaves gen_state equal to bits [63:6] of that received word, so bit 57 holds the newest bit.
- R4: With mode_frame=1, every valid word advances the generator by 64 steps (keystream bit = the keystream bits 39 and 58 steps back, XORed). A data word is output as the input XOR the 64 new keystream bits. gen_state then holds the 58 newest keystream bits, with bit 57 the newest.
- R5: With mode_frame=1 and blk_lock=1, a seed word (header 2'b10, bits [63:58] = 6'b001010) is output unchanged, and gen_state becomes bits [57:0] of that word.
- R6: With mode_frame=1, a sync word (header 2'b10, bits [63:58] = 6'b011110) is output unchanged, and the generator still advances by 64 steps.
- R7: With blk_lock=0, a seed word does not reseed the generator. gen_state advances by 64 steps as it would for any other word.
- R8: desc_valid is 1 exactly one cycle after a cycle with rx_valid=1 and blk_lock=1, and 0 otherwise.
- R9: desc_hdr equals the rx_hdr of the last valid word, one cycle later, unaltered.
- R10: A cycle with rx_valid=0 leaves gen_state, desc_data and desc_hdr unchanged.
- R11: In frame mode, a word whose header is not 2'b10 is treated as data even if its type bits match a seed or sync code: it is descrambled and causes no reseed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_frame | input | 1 | 0 = self-synchronous, 1 = frame-synchronous |
| blk_lock | input | 1 | Block lock from the upstream aligner |
| rx_valid | input | 1 | Word strobe |
| rx_hdr | input | 2 | Control/data header of the word |
| rx_data | input | 64 | Scrambled word |
| desc_valid | output | 1 | Output word strobe |
| desc_hdr | output | 2 | Forwarded header |
| desc_data | output | 64 | Descrambled word |
| gen_state | output | 58 | Live descrambler state for the frame synchronizer |

## Verification
The assertions assume that mode_frame, blk_lock and the header are known whenever rx_valid is sampled high. They also assume that a seed or sync word is recognised from the header and the top six bits alone. The stimulus drives every input on the falling edge from a seeded random source. It switches mode and lock freely, leaves gaps in the strobe, and plants seed and sync words often. Each of these is a legal pattern, so the generator state is exercised across reseeds, mode changes and idle cycles.

// File: rtl/lane_dscr_pkg.sv
package lane_dscr_pkg;
   typedef enum logic [1:0] {
      WORD_DATA = 2'd0,
      WORD_SYNC = 2'd1,
      WORD_SEED = 2'd2
   } word_kind_e;
endpackage

// File: rtl/dscr_word_classify.sv
module dscr_word_classify
   import lane_dscr_pkg::*;
#(
   parameter int          HDR_W     = 2,
   parameter int          TYPE_W    = 6,
   parameter logic [1:0]  CTRL_HDR  = 2'b10,
   parameter logic [5:0]  SYNC_CODE = 6'b011110,
   parameter logic [5:0]  SEED_CODE = 6'b001010
) (
   input  logic [HDR_W-1:0]  hdr,
   input  logic [TYPE_W-1:0] type_bits,
   output word_kind_e        kind
);
   always_comb begin
      kind = WORD_DATA;
      if (hdr == CTRL_HDR[HDR_W-1:0]) begin
         if (type_bits == SEED_CODE[TYPE_W-1:0])
            kind = WORD_SEED;
         else if (type_bits == SYNC_CODE[TYPE_W-1:0])
            kind = WORD_SYNC;
      end
   end
endmodule

// File: rtl/dscr_self_sync.sv
module dscr_self_sync #(
   parameter int DATA_W  = 64,
   parameter int STATE_W = 58,
   parameter int TAP     = 39
) (
   input  logic [DATA_W-1:0]  rx,
   input  logic [STATE_W-1:0] hist,
   output logic [DATA_W-1:0]  plain,
   output logic [STATE_W-1:0] hist_nxt
);
   localparam int EXT_W = DATA_W + STATE_W;
   localparam int NEAR  = STATE_W - TAP;

   logic [EXT_W-1:0] ext;
   assign ext = {rx, hist};

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign plain[i] = ext[STATE_W+i] ^ ext[NEAR+i] ^ ext[i];
   end

   assign hist_nxt = rx[DATA_W-1 -: STATE_W];
endmodule

// File: rtl/dscr_keystream.sv
module dscr_keystream #(
   parameter int DATA_W  = 64,
   parameter int STATE_W = 58,
   parameter int TAP     = 39
) (
   input  logic [STATE_W-1:0] state,
   output logic [DATA_W-1:0]  ks,
   output logic [STATE_W-1:0] state_nxt
);
   localparam int EXT_W = DATA_W + STATE_W;
   localparam int NEAR  = STATE_W - TAP;

   logic [EXT_W-1:0] ext;

   always_comb begin
      ext = '0;
      ext[STATE_W-1:0] = state;
      for (int i = 0; i < DATA_W; i++)
         ext[STATE_W+i] = ext[NEAR+i] ^ ext[i];
   end

   assign ks        = ext[EXT_W-1 -: DATA_W];
   assign state_nxt = ext[EXT_W-1 -: STATE_W];
endmodule

// File: rtl/lane_descrambler.sv
module lane_descrambler
   import lane_dscr_pkg::*;
#(
   parameter int                DATA_W     = 64,
   parameter int                STATE_W    = 58,
   parameter int                TAP        = 39,
   parameter int                HDR_W      = 2,
   parameter int                TYPE_W     = 6,
   parameter bit                FRAME_EN   = 1'b1,
   parameter logic [1:0]        CTRL_HDR   = 2'b10,
   parameter logic [5:0]        SYNC_CODE  = 6'b011110,
   parameter logic [5:0]        SEED_CODE  = 6'b001010,
   parameter logic [STATE_W-1:0] RESET_SEED = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_frame,
   input  logic               blk_lock,
   input  logic               rx_valid,
   input  logic [HDR_W-1:0]   rx_hdr,
   input  logic [DATA_W-1:0]  rx_data,
   output logic               desc_valid,
   output logic [HDR_W-1:0]   desc_hdr,
   output logic [DATA_W-1:0]  desc_data,
   output logic [STATE_W-1:0] gen_state
);
   localparam int TYPE_LSB = DATA_W - TYPE_W;

   // elaboration checks
   if (DATA_W < STATE_W + TYPE_W) begin : g_bad_width
      $error("lane_descrambler: DATA_W must hold the state and the type field");
   end
   if (TAP <= 0 || TAP >= STATE_W) begin : g_bad_tap
      $error("lane_descrambler: TAP must lie strictly inside the state");
   end
   if (HDR_W > 2 || TYPE_W > 6) begin : g_bad_codes
      $error("lane_descrambler: header or type code wider than its parameter");
   end

   logic [STATE_W-1:0] state_q;
   logic [DATA_W-1:0]  ss_plain;
   logic [STATE_W-1:0] ss_state_nxt;
   logic [DATA_W-1:0]  ks;
   logic [STATE_W-1:0] ks_state_nxt;
   logic               frame_sel;
   word_kind_e         kind;
   logic               is_ctrl;
   logic               seed_load;
   logic [STATE_W-1:0] state_nxt;
   logic [DATA_W-1:0]  data_nxt;

   dscr_word_classify #(
      .HDR_W(HDR_W), .TYPE_W(TYPE_W), .CTRL_HDR(CTRL_HDR),
      .SYNC_CODE(SYNC_CODE), .SEED_CODE(SEED_CODE)
   ) u_classify (
      .hdr       (rx_hdr),
      .type_bits (rx_data[DATA_W-1:TYPE_LSB]),
      .kind      (kind)
   );

   dscr_self_sync #(.DATA_W(DATA_W), .STATE_W(STATE_W), .TAP(TAP)) u_self (
      .rx       (rx_data),
      .hist     (state_q),
      .plain    (ss_plain),
      .hist_nxt (ss_state_nxt)
   );

   if (FRAME_EN) begin : g_frame
      dscr_keystream #(.DATA_W(DATA_W), .STATE_W(STATE_W), .TAP(TAP)) u_ks (
         .state     (state_q),
         .ks        (ks),
         .state_nxt (ks_state_nxt)
      );
      assign frame_sel = mode_frame;
   end else begin : g_no_frame
      assign ks           = '0;
      assign ks_state_nxt = ss_state_nxt;
      assign frame_sel    = 1'b0;
   end

   assign is_ctrl   = (kind != WORD_DATA);
   assign seed_load = frame_sel && blk_lock && (kind == WORD_SEED);

   always_comb begin
      if (!frame_sel) begin
         state_nxt = ss_state_nxt;
         data_nxt  = ss_plain;
      end else begin
         state_nxt = seed_load ? rx_data[STATE_W-1:0] : ks_state_nxt;
         data_nxt  = is_ctrl ? rx_data : (rx_data ^ ks);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RESET_SEED;
         desc_valid <= 1'b0;
         desc_hdr   <= '0;
         desc_data  <= '0;
      end else begin
         desc_valid <= rx_valid & blk_lock;
         if (rx_valid) begin
            state_q   <= state_nxt;
            desc_data <= data_nxt;
            desc_hdr  <= rx_hdr;
         end
      end
   end

   assign gen_state = state_q;

   // R8
   valid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(rx_valid && blk_lock));

   // R9
   hdr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> desc_hdr == $past(rx_hdr));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> ($stable(gen_state) && $stable(desc_data)));

   // R3
   self_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !mode_frame) |=> gen_state == $past(rx_data[DATA_W-1 -: STATE_W]));

   // R5
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode_frame && blk_lock && rx_hdr == CTRL_HDR[HDR_W-1:0]
       && rx_data[DATA_W-1:TYPE_LSB] == SEED_CODE[TYPE_W-1:0])
      |=> gen_state == $past(rx_data[STATE_W-1:0]));

   // R6
   ctrl_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && frame_sel && is_ctrl) |=> desc_data == $past(rx_data));
endmodule

// File: tb/tb_lane_descrambler.sv
module tb_lane_descrambler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_frame = 1'b0;
   logic        blk_lock = 1'b0;
   logic        rx_valid = 1'b0;
   logic [1:0]  rx_hdr = '0;
   logic [63:0] rx_data = '0;
   logic        desc_valid;
   logic [1:0]  desc_hdr;
   logic [63:0] desc_data;
   logic [57:0] gen_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model: r[0] is the newest bit, r[k-1] the bit k steps back
   logic [57:0] r;
   logic [63:0] exp_data;
   logic [1:0]  exp_hdr;
   logic        exp_vld;

   always #2 clk = ~clk;

   lane_descrambler dut (
      .clk(clk), .rst_n(rst_n), .mode_frame(mode_frame), .blk_lock(blk_lock),
      .rx_valid(rx_valid), .rx_hdr(rx_hdr), .rx_data(rx_data),
      .desc_valid(desc_valid), .desc_hdr(desc_hdr), .desc_data(desc_data),
      .gen_state(gen_state)
   );

   function automatic logic [57:0] rev58(input logic [57:0] v);
      logic [57:0] o;
      for (int i = 0; i < 58; i++) o[i] = v[57-i];
      return o;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_word(input logic frame, input logic lock,
                             input logic [1:0] hdr, input logic [63:0] d);
      logic is_ctrl, is_seed, b, k, o;
      is_ctrl = frame && hdr == 2'b10 && (d[63:58] == 6'b011110 || d[63:58] == 6'b001010);
      is_seed = frame && lock && hdr == 2'b10 && d[63:58] == 6'b001010;
      for (int i = 0; i < 64; i++) begin
         b = d[i];
         if (!frame) begin
            o = b ^ r[38] ^ r[57];
            r = {r[56:0], b};
         end else begin
            k = r[38] ^ r[57];
            r = {r[56:0], k};
            o = b ^ k;
         end
         exp_data[i] = is_ctrl ? b : o;
      end
      if (is_seed) r = rev58(d[57:0]);
      exp_hdr = hdr;
   endtask

   task automatic send(input string tag, input logic v, input logic frame, input logic lock,
                       input logic [1:0] hdr, input logic [63:0] d);
      @(negedge clk);
      rx_valid = v; mode_frame = frame; blk_lock = lock; rx_hdr = hdr; rx_data = d;
      if (v) model_word(frame, lock, hdr, d);
      exp_vld = v & lock;
      @(posedge clk);
      #1;
      chk("R8 valid", {63'd0, desc_valid}, {63'd0, exp_vld});
      chk({tag, " data"}, desc_data, exp_data);
      chk("R9 header", {62'd0, desc_hdr}, {62'd0, exp_hdr});
      chk({tag, " state"}, {6'd0, gen_state}, {6'd0, rev58(r)});
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [1:0]  h;
      logic        fr, lk, vv;
      int          sel;
      void'($urandom(32'd20240611));
      r = '1; exp_data = '0; exp_hdr = '0; exp_vld = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 valid", {63'd0, desc_valid}, 64'd0);
      chk("R1 state", {6'd0, gen_state}, {6'd0, 58'h3FF_FFFF_FFFF_FFFF});
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after release", {63'd0, desc_valid}, 64'd0);

      // R2 / R3 directed self-sync words
      send("R2", 1, 0, 1, 2'b01, 64'h0123_4567_89AB_CDEF);
      send("R3", 1, 0, 1, 2'b10, 64'hFFFF_0000_FFFF_0000);
      send("R2", 1, 0, 1, 2'b01, 64'h0);
      // R10 idle
      send("R10", 0, 0, 1, 2'b11, 64'hDEAD_BEEF_DEAD_BEEF);
      // R5 seed then data in frame mode
      send("R5", 1, 1, 1, 2'b10, {6'b001010, 58'h155_5555_AAAA_1234});
      send("R4", 1, 1, 1, 2'b01, 64'h0);
      send("R4", 1, 1, 1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF);
      // R6 sync word passes and advances
      send("R6", 1, 1, 1, 2'b10, {6'b011110, 58'h0AB_CDEF_0123_4567});
      // R7 seed without lock is not loaded
      send("R7", 1, 1, 0, 2'b10, {6'b001010, 58'h000_0000_0000_0001});
      // R11 seed code under data header
      send("R11", 1, 1, 1, 2'b01, {6'b001010, 58'h3FF_0000_FFFF_0000});
      send("R10", 0, 1, 1, 2'b10, 64'h0);
      // zero seed gives a zero keystream
      send("R5", 1, 1, 1, 2'b10, {6'b001010, 58'h0});
      send("R4", 1, 1, 1, 2'b01, 64'h5A5A_5A5A_5A5A_5A5A);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         sel = $urandom_range(0, 9);
         vv  = ($urandom_range(0, 7) != 0);
         fr  = ($urandom_range(0, 3) != 0);
         lk  = ($urandom_range(0, 5) != 0);
         h   = 2'($urandom_range(0, 3));
         d   = {$urandom, $urandom};
         if (sel == 0) begin h = 2'b10; d[63:58] = 6'b001010; end
         else if (sel == 1) begin h = 2'b10; d[63:58] = 6'b011110; end
         else if (sel == 2) begin d[63:58] = 6'b001010; end
         send(fr ? "R4" : "R2", vv, fr, lk, h, d);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule